// File: doc/BRIEF.md
# Dual-Format Stereo Audio Serial Receiver

This block receives stereo PCM audio from a three-wire serial link: a bit clock, a frame clock that selects the channel, and one data line. All three lines are sampled by the block's own system clock. The block finds rising edges of the bit clock and counts bits within each channel slot. It shifts each sample in MSB first and hands one left sample and one right sample to downstream logic as a frame-aligned pair.

A static format input chooses the framing. In justified framing the MSB arrives in the first bit-clock period after a frame-clock change. In I2S framing it arrives one bit-clock period later. Each slot keeps exactly 24 bits, whatever the bit-clock rate. Bits that arrive after the 24th are discarded. If the frame clock changes before 24 bits have arrived, the missing low bits are zero. The system clock must run at least four times faster than the bit clock, so that every bit-clock level is seen by the synchronizer.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `valid_o` is low and `left_o` and `right_o` are all zeros.
- R2: With `fmt_i2s` low (justified framing), a high frame clock marks the left slot. The bit sampled on the first bit-clock rising edge after a frame-clock change is the sample MSB.
- R3: With `fmt_i2s` high (I2S framing), a low frame clock marks the left slot. The MSB is the bit sampled on the second bit-clock rising edge after a frame-clock change. The bit sampled on the edge where the change is first seen belongs to the slot that is ending.
- R4: Samples are 24-bit two's complement, received MSB first. The first received bit appears on bit 23 of the output, and later bits fill downward to bit 0, so negative values come out unchanged.
- R5: Bits beyond the 24th within one slot have no effect on the output sample.
- R6: A slot that ends after fewer than 24 bits produces a sample whose unreceived low-order bits are zero.
- R7: `valid_o` is high for exactly one system-clock cycle once a right slot completes, and `left_o` and `right_o` then show that frame's pair together. Between pulses both outputs hold their value.
- R8: Framing is correct at 48 and at 64 bit-clock cycles per frame, in both formats.
- R9: After reset, a pair is emitted only when a complete left slot precedes a complete right slot. A partial slot seen before the first frame-clock change is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i2s | input | 1 | Framing select: 0 justified, 1 I2S (static) |
| ser_bclk | input | 1 | Serial bit clock |
| ser_fclk | input | 1 | Serial frame/channel clock |
| ser_data | input | 1 | Serial data, MSB first |
| left_o | output | SAMPLE_W | Left sample of the last complete frame |
| right_o | output | SAMPLE_W | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle strobe marking a new pair |

## Verification
The assertions check, on every cycle, several timing rules: the reset state of the outputs, that the strobe lasts one cycle, that the outputs are stable between strobes, and that a strobe follows only a finished right slot, which itself follows a bit-clock edge. The numeric content of the samples can only be shown by the bench's scenarios. These cover MSB placement in each framing, the dropping of trailing bits, zero fill of short slots, both frame rates, and the discarding of the partial slot seen after reset.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam int DEF_SAMPLE_W = 24;

  typedef enum logic {
    FMT_JUSTIFIED = 1'b0,
    FMT_I2S       = 1'b1
  } rx_fmt_e;
endpackage

// File: rtl/arx_input_sync.sv
module arx_input_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic fclk_in,
  input  logic data_in,
  output logic bit_stb,
  output logic fr_lvl,
  output logic bit_val
);
  localparam int LAST = STAGES - 1;

  logic [2:0] pipe [STAGES];
  logic       bclk_d;

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= {bclk_in, fclk_in, data_in};
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) bclk_d <= 1'b0;
    else     bclk_d <= pipe[LAST][2];
  end

  assign bit_stb = pipe[LAST][2] & ~bclk_d;
  assign fr_lvl  = pipe[LAST][1];
  assign bit_val = pipe[LAST][0];
endmodule

// File: rtl/arx_slot_shifter.sv
module arx_slot_shifter
  import audio_rx_pkg::*;
#(
  parameter int W = DEF_SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fmt_i2s,
  input  logic         bit_stb,
  input  logic         fr_lvl,
  input  logic         bit_val,
  output logic         slot_done,
  output logic         slot_left,
  output logic [W-1:0] slot_data
);
  localparam int            CW       = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(W);
  localparam logic [W-1:0]  TOP_BIT  = {1'b1, {(W-1){1'b0}}};

  logic          is_i2s;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh, sh_upd, mask;
  logic          primed, started, prev_f;

  assign is_i2s = (rx_fmt_e'(fmt_i2s) == FMT_I2S);
  // Position of the next bit; shifts out to zero once the slot is full.
  assign mask   = TOP_BIT >> cnt;
  assign sh_upd = sh | (bit_val ? mask : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sh        <= '0;
      primed    <= 1'b0;
      started   <= 1'b0;
      prev_f    <= 1'b0;
      slot_done <= 1'b0;
      slot_left <= 1'b0;
      slot_data <= '0;
    end else begin
      slot_done <= 1'b0;
      if (bit_stb) begin
        primed <= 1'b1;
        prev_f <= fr_lvl;
        if (primed && (fr_lvl != prev_f)) begin
          // Slot boundary: close the old slot, open the new one.
          slot_done <= started;
          slot_left <= prev_f ^ is_i2s;
          slot_data <= is_i2s ? sh_upd : sh;
          started   <= 1'b1;
          if (is_i2s) begin
            sh  <= '0;
            cnt <= '0;
          end else begin
            sh  <= bit_val ? TOP_BIT : '0;
            cnt <= CW'(1);
          end
        end else if (primed && (cnt != CNT_MAX)) begin
          sh  <= sh_upd;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/arx_frame_pair.sv
module arx_frame_pair #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         slot_done,
  input  logic         slot_left,
  input  logic [W-1:0] slot_data,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);
  logic [W-1:0] left_hold;
  logic         have_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
      have_left <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (slot_done) begin
        if (slot_left) begin
          left_hold <= slot_data;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_o    <= left_hold;
          right_o   <= slot_data;
          valid_o   <= 1'b1;
          have_left <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audio_rx_pkg::*;
#(
  parameter int SAMPLE_W    = DEF_SAMPLE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fmt_i2s,
  input  logic                ser_bclk,
  input  logic                ser_fclk,
  input  logic                ser_data,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic                bit_stb, fr_lvl, bit_val;
  logic                slot_done, slot_left;
  logic [SAMPLE_W-1:0] slot_data;

  arx_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .bclk_in(ser_bclk), .fclk_in(ser_fclk), .data_in(ser_data),
    .bit_stb(bit_stb), .fr_lvl(fr_lvl), .bit_val(bit_val)
  );

  arx_slot_shifter #(.W(SAMPLE_W)) u_slot (
    .clk(clk), .rst(rst), .fmt_i2s(fmt_i2s),
    .bit_stb(bit_stb), .fr_lvl(fr_lvl), .bit_val(bit_val),
    .slot_done(slot_done), .slot_left(slot_left), .slot_data(slot_data)
  );

  arx_frame_pair #(.W(SAMPLE_W)) u_pair (
    .clk(clk), .rst(rst),
    .slot_done(slot_done), .slot_left(slot_left), .slot_data(slot_data),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_o,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         bit_stb,
  input logic         slot_done,
  input logic         slot_left
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!valid_o && left_o == '0 && right_o == '0));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  a_r9_after_right_slot: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($past(slot_done) && !$past(slot_left)));

  a_r8_slot_on_bit_edge: assert property (@(posedge clk) disable iff (rst)
    slot_done |-> $past(bit_stb));
endmodule

bind audio_serial_rx audio_serial_rx_chk #(.W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .valid_o(valid_o), .left_o(left_o), .right_o(right_o),
  .bit_stb(bit_stb), .slot_done(slot_done), .slot_left(slot_left)
);

// File: tb/sim_audio_serial_rx.sv
`timescale 1ns/1ps
module sim_audio_serial_rx;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fmt_i2s = 1'b0;
  logic         ser_bclk = 1'b0;
  logic         ser_fclk = 1'b0;
  logic         ser_data = 1'b0;
  logic [W-1:0] left_o, right_o;
  logic         valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic carry = 1'b0;

  logic [W-1:0] q_l[$];
  logic [W-1:0] q_r[$];
  int  wide_pulses = 0;
  logic prev_v = 1'b0;

  always #10 clk = ~clk;

  audio_serial_rx u0 (
    .clk(clk), .rst(rst), .fmt_i2s(fmt_i2s),
    .ser_bclk(ser_bclk), .ser_fclk(ser_fclk), .ser_data(ser_data),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (valid_o) begin
      q_l.push_back(left_o);
      q_r.push_back(right_o);
      if (prev_v) wide_pulses++;
    end
    prev_v = valid_o;
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic f, input logic d);
    @(negedge clk);
    ser_bclk = 1'b0; ser_fclk = f; ser_data = d;
    repeat (2) @(negedge clk);
    ser_bclk = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic wbit(input logic [W-1:0] v, input int k, input logic junk);
    return (k < W) ? v[W-1-k] : junk;
  endfunction

  task automatic send_slot(input logic lvl, input logic [W-1:0] v, input int n,
                           input logic junk);
    for (int i = 0; i < n; i++) begin
      if (fmt_i2s) bit_cycle(lvl, (i == 0) ? carry : wbit(v, i - 1, junk));
      else         bit_cycle(lvl, wbit(v, i, junk));
    end
    carry = wbit(v, n - 1, junk);
  endtask

  task automatic start(input logic fmt, input logic first_lvl);
    fmt_i2s = fmt; carry = 1'b0;
    ser_bclk = 1'b0; ser_fclk = first_lvl; ser_data = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    q_l.delete(); q_r.delete();
    for (int i = 0; i < 5; i++) bit_cycle(first_lvl, 1'b1);
  endtask

  task automatic flush(input logic lvl);
    bit_cycle(lvl, fmt_i2s ? carry : 1'b0);
    for (int i = 0; i < 3; i++) bit_cycle(lvl, 1'b0);
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_pairs(input string req, input logic [W-1:0] el[],
                              input logic [W-1:0] er[]);
    chk(q_l.size() == el.size(), req, W'(q_l.size()), W'(el.size()));
    for (int i = 0; i < el.size() && i < q_l.size(); i++) begin
      chk(q_l[i] == el[i], {req, " left"}, q_l[i], el[i]);
      chk(q_r[i] == er[i], {req, " right"}, q_r[i], er[i]);
    end
  endtask

  // R1
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid", W'(valid_o), '0);
    chk(left_o == '0, "R1 left", left_o, '0);
    chk(right_o == '0, "R1 right", right_o, '0);
  endtask

  // R2 R4 R5 R8: justified, 64 per frame, junk ones after bit 24
  task automatic t_just64();
    start(1'b0, 1'b0);
    send_slot(1'b1, 24'h123456, 32, 1'b1);
    send_slot(1'b0, 24'h800001, 32, 1'b1);
    send_slot(1'b1, 24'hFFFFFE, 32, 1'b0);
    send_slot(1'b0, 24'h0A5A5A, 32, 1'b1);
    flush(1'b1);
    expect_pairs("R2 R4 R5 just64", '{24'h123456, 24'hFFFFFE},
                 '{24'h800001, 24'h0A5A5A});
  endtask

  // R3 R5 R8: I2S, 64 per frame
  task automatic t_i2s64();
    start(1'b1, 1'b1);
    send_slot(1'b0, 24'hC0FFEE, 32, 1'b1);
    send_slot(1'b1, 24'h7FFFFF, 32, 1'b1);
    send_slot(1'b0, 24'h000001, 32, 1'b1);
    send_slot(1'b1, 24'h900009, 32, 1'b0);
    flush(1'b0);
    expect_pairs("R3 R5 i2s64", '{24'hC0FFEE, 24'h000001},
                 '{24'h7FFFFF, 24'h900009});
  endtask

  // R8: 48 per frame in both framings (I2S LSB lands on boundary edge)
  task automatic t_rate48();
    start(1'b0, 1'b0);
    send_slot(1'b1, 24'hABCDEF, 24, 1'b0);
    send_slot(1'b0, 24'h000003, 24, 1'b0);
    flush(1'b1);
    expect_pairs("R8 just48", '{24'hABCDEF}, '{24'h000003});
    start(1'b1, 1'b1);
    send_slot(1'b0, 24'h555555, 24, 1'b0);
    send_slot(1'b1, 24'hAAAAAB, 24, 1'b0);
    flush(1'b0);
    expect_pairs("R8 i2s48", '{24'h555555}, '{24'hAAAAAB});
  endtask

  // R6: 20-bit slots, low four bits zero-filled
  task automatic t_short();
    start(1'b0, 1'b0);
    send_slot(1'b1, 24'hFFFFFF, 20, 1'b1);
    send_slot(1'b0, 24'h87654F, 20, 1'b1);
    flush(1'b1);
    expect_pairs("R6 short", '{24'hFFFFF0}, '{24'h876540});
  endtask

  // R9 R7: stream starts mid left slot; pulse width and hold
  task automatic t_pairing();
    logic [W-1:0] hl, hr;
    start(1'b0, 1'b1);
    send_slot(1'b0, 24'h111111, 32, 1'b0);
    send_slot(1'b1, 24'h222222, 32, 1'b0);
    send_slot(1'b0, 24'h333333, 32, 1'b0);
    flush(1'b1);
    expect_pairs("R9 pairing", '{24'h222222}, '{24'h333333});
    hl = left_o; hr = right_o;
    repeat (40) @(negedge clk);
    chk(left_o == hl && right_o == hr, "R7 hold", left_o, hl);
    chk(wide_pulses == 0, "R7 pulse width", W'(wide_pulses), '0);
  endtask

  initial begin
    t_reset();
    t_just64();
    t_i2s64();
    t_rate48();
    t_short();
    t_pairing();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule